// File: doc/BRIEF.md
# Character Panel Row Scanner

This block drives a passive character panel with 16 common lines and 80 segment lines at 1/16 duty. Each common line shows one dot row of a text line. The first text line uses commons 1 to 8 and the second uses commons 9 to 16. Each text line holds 16 cells, and each cell is 5 dots wide.

For every common period the block performs four steps:

- It walks the 16 cell positions of the row it is preparing.
- It reads each character code from the display RAM through a read port that returns data in the same cycle.
- It fetches the matching dot row through a pattern-lookup port.
- It shifts the five dots of each cell into an 80-bit register.

At the last clock of the period, the collected bits move to the segment outputs on the same edge that selects the next common. This keeps a partly shifted row off the panel.

The scanner applies several display settings:

- a horizontal scroll offset, applied within each line;
- display blanking;
- a cursor underline on the eighth dot row;
- a blinking block over the cursor cell;
- mirroring of the common order and of the segment order, which adapts the panel to mounting orientation.

All settings are plain level inputs. They are expected to stay steady for a whole common period. The outputs are logic-level; bias generation is done elsewhere.

Top module: `lcd_scan_gen`

## Requirements
- R1: After reset, `com_out` and `seg_out` are all zero until the first row is latched. That happens at the CLKS_PER_COM-th rising edge after reset is released.
- R2: After the first latch exactly one common is active. Row index r (0..15) drives `com_out[r]`. The row advances by one every CLKS_PER_COM cycles and wraps from 15 to 0.
- R3: Cell position p (0..15) of row r reads RAM address base + ((p + cfg_shift) mod 16). The base is 0x00 for rows 0..7 and 0x40 for rows 8..15. It requests dot row r mod 8. Dot bit 4 (leftmost column) goes to `seg_out[5p]` and dot bit 0 goes to `seg_out[5p+4]`.
- R4: For dot row 7 the looked-up dots are ignored. The cell shows 5'b11111 when `cfg_cursor_on` is 1 and its RAM address equals `cursor_addr`; otherwise it shows 0.
- R5: Frames are counted from reset in epochs of BLINK_FRAMES frames. Epochs 0, 2, 4, … are even and epochs 1, 3, … are odd. With `cfg_blink_on` at 1 during an odd epoch, the cell whose address equals `cursor_addr` shows 5'b11111 on all eight dot rows. During an even epoch it shows the character.
- R6: With `cfg_disp_on` at 0, every latched row has all segments at 0 while the commons keep scanning.
- R7: With `cfg_two_line` at 0, rows 8..15 latch all-zero segments.
- R8: With `cfg_com_mirror` at 1, row r drives `com_out[15-r]`.
- R9: With `cfg_seg_mirror` at 1, `seg_out[i]` carries the bit that R3 places at index 79-i.
- R10: `seg_out` and `com_out` change only on the latch edge. Between latches they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_disp_on | input | 1 | 1 shows data, 0 blanks all segments |
| cfg_cursor_on | input | 1 | Enables underline on dot row 7 |
| cfg_blink_on | input | 1 | Enables the blinking block at the cursor cell |
| cfg_two_line | input | 1 | 1 shows the second text line on commons 9..16 |
| cfg_com_mirror | input | 1 | Reverses common order |
| cfg_seg_mirror | input | 1 | Reverses segment order |
| cfg_shift | input | 4 | Horizontal scroll offset in cells |
| cursor_addr | input | 7 | RAM address of the cursor cell |
| ram_addr | output | 7 | Display RAM read address |
| ram_code | input | 8 | Character code read back in the same cycle |
| pat_code | output | 8 | Character code sent to pattern lookup |
| pat_row | output | 3 | Dot row sent to pattern lookup |
| pat_dots | input | 5 | Dot row returned in the same cycle, bit 4 leftmost |
| com_out | output | 16 | One-hot common select |
| seg_out | output | 80 | Latched segment data |

## Verification
The bench shortens the timing parameters so that the blink behaviour can be reached in a short run:

- CLKS_PER_COM is 24 instead of 160. A frame then takes 384 cycles.
- BLINK_FRAMES is 2 instead of 32. The blink phase then flips every second frame.

Both blink epochs, every mirror setting, blanking, single-line mode and scroll wrap are covered within twelve frames. All other parameters keep their defaults, so the 16-cell, 80-segment mapping and the 0x40 line stride are tested at full size.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   typedef struct packed {
      logic disp_on;
      logic cursor_on;
      logic blink_on;
      logic two_line;
      logic com_mirror;
      logic seg_mirror;
   } scan_cfg_t;

   function automatic int lines_of(input int num_com, input int rows);
      return num_com / rows;
   endfunction

endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
   parameter int NUM_COM      = 16,
   parameter int CHARS        = 16,
   parameter int CLKS_PER_COM = 160,
   parameter int BLINK_FRAMES = 32,
   localparam int CNTW = $clog2(CLKS_PER_COM),
   localparam int POSW = $clog2(CHARS),
   localparam int ROWW = $clog2(NUM_COM)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic            fetch_en,
   output logic [POSW-1:0] fetch_pos,
   output logic            latch_en,
   output logic [ROWW-1:0] row_idx,
   output logic            blink_phase
);
   localparam int FW = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;
   localparam logic [CNTW-1:0] CNT_LAST  = CNTW'(CLKS_PER_COM - 1);
   localparam logic [CNTW-1:0] CNT_CHARS = CNTW'(CHARS);
   localparam logic [ROWW-1:0] ROW_LAST  = ROWW'(NUM_COM - 1);
   localparam logic [FW-1:0]   FR_LAST   = FW'(BLINK_FRAMES - 1);

   logic [CNTW-1:0] cnt_q;
   logic [FW-1:0]   frame_q;

   assign fetch_en  = (cnt_q < CNT_CHARS);
   assign fetch_pos = cnt_q[POSW-1:0];
   assign latch_en  = (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         row_idx     <= '0;
         frame_q     <= '0;
         blink_phase <= 1'b0;
      end else if (latch_en) begin
         cnt_q <= '0;
         if (row_idx == ROW_LAST) begin
            row_idx <= '0;
            if (frame_q == FR_LAST) begin
               frame_q     <= '0;
               blink_phase <= ~blink_phase;
            end else begin
               frame_q <= frame_q + 1'b1;
            end
         end else begin
            row_idx <= row_idx + 1'b1;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lcd_scan_cell.sv
module lcd_scan_cell
   import lcd_scan_pkg::*;
#(
   parameter int NUM_COM     = 16,
   parameter int CHARS       = 16,
   parameter int CHAR_W      = 5,
   parameter int ROWS        = 8,
   parameter int AW          = 7,
   parameter int CW          = 8,
   parameter int LINE_STRIDE = 64,
   localparam int POSW = $clog2(CHARS),
   localparam int ROWW = $clog2(NUM_COM),
   localparam int RW   = $clog2(ROWS)
) (
   input  scan_cfg_t         cfg,
   input  logic [POSW-1:0]   shift,
   input  logic [AW-1:0]     cursor_addr,
   input  logic [ROWW-1:0]   row_idx,
   input  logic [POSW-1:0]   fetch_pos,
   input  logic              blink_phase,
   output logic [AW-1:0]     ram_addr,
   input  logic [CW-1:0]     ram_code,
   output logic [CW-1:0]     pat_code,
   output logic [RW-1:0]     pat_row,
   input  logic [CHAR_W-1:0] pat_dots,
   output logic [CHAR_W-1:0] cell_group
);
   localparam logic [RW-1:0] CURSOR_ROW = RW'(ROWS - 1);

   logic [ROWW-1:0]   line_idx;
   logic [POSW-1:0]   col;
   logic              cursor_hit;
   logic [CHAR_W-1:0] dots;

   assign line_idx = row_idx >> RW;
   assign col      = fetch_pos + shift;
   assign ram_addr = AW'(line_idx) * AW'(LINE_STRIDE) + AW'(col);
   assign pat_code = ram_code;
   assign pat_row  = row_idx[RW-1:0];

   assign cursor_hit = (ram_addr == cursor_addr);

   always_comb begin
      if (cfg.blink_on && blink_phase && cursor_hit)
         dots = '1;
      else if (pat_row == CURSOR_ROW)
         dots = (cfg.cursor_on && cursor_hit) ? '1 : '0;
      else
         dots = pat_dots;
   end

   for (genvar c = 0; c < CHAR_W; c++) begin : g_col
      assign cell_group[c] = dots[CHAR_W-1-c];
   end
endmodule

// File: rtl/lcd_scan_shift.sv
module lcd_scan_shift #(
   parameter int NUM_COM = 16,
   parameter int CHARS   = 16,
   parameter int CHAR_W  = 5,
   localparam int SEGS = CHARS * CHAR_W,
   localparam int ROWW = $clog2(NUM_COM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_en,
   input  logic [CHAR_W-1:0] cell_group,
   input  logic              latch_en,
   input  logic              blank,
   input  logic              com_mirror,
   input  logic              seg_mirror,
   input  logic [ROWW-1:0]   row_idx,
   output logic [NUM_COM-1:0] com_out,
   output logic [SEGS-1:0]   seg_out
);
   logic [SEGS-1:0]    sreg_q;
   logic [SEGS-1:0]    sreg_rev;
   logic [SEGS-1:0]    seg_next;
   logic [NUM_COM-1:0] com_next;

   for (genvar i = 0; i < SEGS; i++) begin : g_segrev
      assign sreg_rev[i] = sreg_q[SEGS-1-i];
   end

   for (genvar k = 0; k < NUM_COM; k++) begin : g_com
      assign com_next[k] = com_mirror ? (row_idx == ROWW'(NUM_COM-1-k))
                                      : (row_idx == ROWW'(k));
   end

   assign seg_next = blank ? '0 : (seg_mirror ? sreg_rev : sreg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q  <= '0;
         seg_out <= '0;
         com_out <= '0;
      end else begin
         if (fetch_en)
            sreg_q <= {cell_group, sreg_q[SEGS-1:CHAR_W]};
         if (latch_en) begin
            seg_out <= seg_next;
            com_out <= com_next;
         end
      end
   end
endmodule

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen
   import lcd_scan_pkg::*;
#(
   parameter int NUM_COM      = 16,
   parameter int CHARS        = 16,
   parameter int CHAR_W       = 5,
   parameter int ROWS         = 8,
   parameter int CLKS_PER_COM = 160,
   parameter int BLINK_FRAMES = 32,
   parameter int AW           = 7,
   parameter int CW           = 8,
   parameter int LINE_STRIDE  = 64,
   localparam int SEGS = CHARS * CHAR_W,
   localparam int POSW = $clog2(CHARS),
   localparam int RW   = $clog2(ROWS)
) (
   input  logic                cfg_disp_on,
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_cursor_on,
   input  logic                cfg_blink_on,
   input  logic                cfg_two_line,
   input  logic                cfg_com_mirror,
   input  logic                cfg_seg_mirror,
   input  logic [POSW-1:0]     cfg_shift,
   input  logic [AW-1:0]       cursor_addr,
   output logic [AW-1:0]       ram_addr,
   input  logic [CW-1:0]       ram_code,
   output logic [CW-1:0]       pat_code,
   output logic [RW-1:0]       pat_row,
   input  logic [CHAR_W-1:0]   pat_dots,
   output logic [NUM_COM-1:0]  com_out,
   output logic [SEGS-1:0]     seg_out
);
   localparam int ROWW  = $clog2(NUM_COM);
   localparam int LINES = lines_of(NUM_COM, ROWS);

   if (CLKS_PER_COM <= CHARS) begin : g_bad_period
      $error("CLKS_PER_COM must exceed CHARS");
   end
   if ((1 << POSW) != CHARS) begin : g_bad_chars
      $error("CHARS must be a power of two");
   end
   if ((1 << RW) != ROWS || LINES * ROWS != NUM_COM) begin : g_bad_rows
      $error("ROWS must be a power of two dividing NUM_COM");
   end
   if (LINES < 1 || (LINES - 1) * LINE_STRIDE + CHARS > (1 << AW)) begin : g_bad_addr
      $error("line layout does not fit the address width");
   end
   if (BLINK_FRAMES < 1) begin : g_bad_blink
      $error("BLINK_FRAMES must be at least one");
   end

   scan_cfg_t         cfg;
   logic              fetch_en;
   logic [POSW-1:0]   fetch_pos;
   logic              latch_en;
   logic [ROWW-1:0]   row_idx;
   logic              blink_phase;
   logic [CHAR_W-1:0] cell_group;
   logic              blank;

   assign cfg = '{disp_on:    cfg_disp_on,
                  cursor_on:  cfg_cursor_on,
                  blink_on:   cfg_blink_on,
                  two_line:   cfg_two_line,
                  com_mirror: cfg_com_mirror,
                  seg_mirror: cfg_seg_mirror};

   assign blank = !cfg.disp_on || (!cfg.two_line && ((row_idx >> RW) != '0));

   lcd_scan_timing #(
      .NUM_COM(NUM_COM), .CHARS(CHARS),
      .CLKS_PER_COM(CLKS_PER_COM), .BLINK_FRAMES(BLINK_FRAMES)
   ) u_timing (
      .clk(clk), .rst_n(rst_n),
      .fetch_en(fetch_en), .fetch_pos(fetch_pos), .latch_en(latch_en),
      .row_idx(row_idx), .blink_phase(blink_phase)
   );

   lcd_scan_cell #(
      .NUM_COM(NUM_COM), .CHARS(CHARS), .CHAR_W(CHAR_W), .ROWS(ROWS),
      .AW(AW), .CW(CW), .LINE_STRIDE(LINE_STRIDE)
   ) u_cell (
      .cfg(cfg), .shift(cfg_shift), .cursor_addr(cursor_addr),
      .row_idx(row_idx), .fetch_pos(fetch_pos), .blink_phase(blink_phase),
      .ram_addr(ram_addr), .ram_code(ram_code),
      .pat_code(pat_code), .pat_row(pat_row), .pat_dots(pat_dots),
      .cell_group(cell_group)
   );

   lcd_scan_shift #(
      .NUM_COM(NUM_COM), .CHARS(CHARS), .CHAR_W(CHAR_W)
   ) u_shift (
      .clk(clk), .rst_n(rst_n),
      .fetch_en(fetch_en), .cell_group(cell_group), .latch_en(latch_en),
      .blank(blank), .com_mirror(cfg.com_mirror), .seg_mirror(cfg.seg_mirror),
      .row_idx(row_idx), .com_out(com_out), .seg_out(seg_out)
   );
endmodule

// File: rtl/lcd_scan_gen_chk.sv
module lcd_scan_gen_chk #(
   parameter int NUM_COM      = 16,
   parameter int SEGS         = 80,
   parameter int CLKS_PER_COM = 160
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_disp_on,
   input logic [NUM_COM-1:0] com_out,
   input logic [SEGS-1:0]    seg_out
);
   localparam int CNTW = $clog2(CLKS_PER_COM);
   localparam logic [CNTW-1:0] LAST = CNTW'(CLKS_PER_COM - 1);

   logic [CNTW-1:0] tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             tick_q <= '0;
      else if (tick_q == LAST) tick_q <= '0;
      else                    tick_q <= tick_q + 1'b1;
   end

   assert_blank_before_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (com_out == '0) |-> (seg_out == '0));

   assert_com_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(com_out));

   assert_com_change_selects_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(com_out) |-> ($countones(com_out) == 1));

   assert_off_blanks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(com_out) && !$past(cfg_disp_on)) |-> (seg_out == '0));

   assert_hold_between_latches_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_q != LAST) |=> ($stable(seg_out) && $stable(com_out)));
endmodule

bind lcd_scan_gen lcd_scan_gen_chk #(
   .NUM_COM(NUM_COM), .SEGS(SEGS), .CLKS_PER_COM(CLKS_PER_COM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_disp_on(cfg_disp_on),
   .com_out(com_out), .seg_out(seg_out)
);

// File: tb/lcd_scan_gen_bench.sv
module lcd_scan_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CLKS  = 24;
   localparam int BLINK = 2;
   localparam int NPER  = 192;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic c_disp, c_cur, c_blink, c_two, c_cm, c_sm;
   logic [3:0]  c_shift;
   logic [6:0]  c_caddr;
   logic [6:0]  ram_addr;
   logic [7:0]  ram_code;
   logic [7:0]  pat_code;
   logic [2:0]  pat_row;
   logic [4:0]  pat_dots;
   logic [15:0] com_out;
   logic [79:0] seg_out;
   logic [7:0]  ram [0:127];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [4:0] patf(input logic [7:0] code, input logic [2:0] row);
      int v;
      v = int'(code) * 3 + int'(row) * 7 + int'(code >> 4);
      return v[4:0];
   endfunction

   assign ram_code = ram[ram_addr];
   assign pat_dots = patf(pat_code, pat_row);

   lcd_scan_gen #(.CLKS_PER_COM(CLKS), .BLINK_FRAMES(BLINK)) u_lcd_scan_gen (
      .cfg_disp_on(c_disp), .clk(clk), .rst_n(rst_n),
      .cfg_cursor_on(c_cur), .cfg_blink_on(c_blink), .cfg_two_line(c_two),
      .cfg_com_mirror(c_cm), .cfg_seg_mirror(c_sm), .cfg_shift(c_shift),
      .cursor_addr(c_caddr), .ram_addr(ram_addr), .ram_code(ram_code),
      .pat_code(pat_code), .pat_row(pat_row), .pat_dots(pat_dots),
      .com_out(com_out), .seg_out(seg_out)
   );

   function automatic logic [79:0] exp_seg(input int r, input bit phase);
      logic [79:0] n;
      logic [6:0]  a;
      logic [4:0]  d;
      n = '0;
      for (int p = 0; p < 16; p++) begin
         a = 7'((r >= 8 ? 64 : 0) + ((p + int'(c_shift)) % 16));
         if (c_blink && phase && a == c_caddr) d = 5'h1f;
         else if (r % 8 == 7) d = (c_cur && a == c_caddr) ? 5'h1f : 5'h00;
         else d = patf(ram[a], 3'(r % 8));
         for (int c = 0; c < 5; c++) n[p*5+c] = d[4-c];
      end
      if (!c_disp || (!c_two && r >= 8)) n = '0;
      if (c_sm) begin
         logic [79:0] m;
         for (int i = 0; i < 80; i++) m[i] = n[79-i];
         n = m;
      end
      return n;
   endfunction

   task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input int jn);
      int r, f;
      r = jn % 16;
      f = jn / 16;
      c_disp = 1; c_two = 1; c_cm = 0; c_sm = 0; c_cur = 1; c_blink = 0; c_shift = 0;
      c_caddr = 7'((r >= 8 ? 64 : 0) + int'($urandom % 16));
      case (f)
         0: ;
         1: c_shift = 4'd5;
         2: c_blink = 1;
         3: c_two = 0;
         4: c_disp = 0;
         5: c_cm = 1;
         6: begin c_sm = 1; c_blink = 1; end
         7: begin c_cur = 0; c_shift = 4'd15; end
         default: begin
            c_disp = 1'($urandom); c_two = 1'($urandom); c_cm = 1'($urandom);
            c_sm = 1'($urandom); c_cur = 1'($urandom); c_blink = 1'($urandom);
            c_shift = 4'($urandom);
            if (r == 0) for (int i = 0; i < 128; i++) ram[i] = 8'($urandom);
         end
      endcase
   endtask

   initial begin
      logic [79:0] pexp_seg;
      logic [15:0] pexp_com;
      logic [79:0] es;
      logic [15:0] ec;
      string tg;
      bit ph;
      int r;
      void'($urandom(32'h1c5d));
      for (int i = 0; i < 128; i++) ram[i] = 8'($urandom);
      set_cfg(0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset com", 80'(com_out), 80'(0));
      check("R1 reset seg", seg_out, '0);
      rst_n = 1'b1;
      pexp_seg = '0;
      pexp_com = '0;
      for (int j = 0; j < NPER; j++) begin
         repeat (CLKS - 1) @(posedge clk);
         @(negedge clk);
         if (j == 0) begin
            check("R1 before first latch com", 80'(com_out), 80'(0));
            check("R1 before first latch seg", seg_out, '0);
         end else begin
            check("R10 hold com", 80'(com_out), 80'(pexp_com));
            check("R10 hold seg", seg_out, pexp_seg);
         end
         @(posedge clk);
         @(negedge clk);
         r  = j % 16;
         ph = ((j / 16) / BLINK) % 2 == 1;
         ec = 16'(1) << (c_cm ? 15 - r : r);
         es = exp_seg(r, ph);
         check(c_cm ? "R8 mirrored common" : "R2 common select", 80'(com_out), 80'(ec));
         if (!c_disp) tg = "R6 display off";
         else if (!c_two && r >= 8) tg = "R7 single line blank";
         else if (c_sm) tg = "R9 segment mirror";
         else if (c_blink && ph) tg = "R5 blink block";
         else if (r % 8 == 7) tg = "R4 cursor row";
         else tg = "R3 cell mapping";
         check(tg, seg_out, es);
         pexp_seg = es;
         pexp_com = ec;
         set_cfg(j + 1);
      end
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule